// File: doc/BRIEF.md
# SWD host transaction engine

This block is the host end of a Serial Wire Debug link. A single request gives an access-port or debug-port select, a direction, a two-bit register address, 32 bits of write data and an idle-cycle hint. The engine frames the 8-bit request packet and generates the debug clock from the system clock. It drives and releases the data line through separate output-enable and output-value signals, and it inserts the turnaround periods. It samples the target's acknowledge, moves the data word with its parity bit in the proper direction and then reports a result.

A transfer ends with a one-cycle `done` pulse that carries a two-bit status and the read data. Status codes are 0 = OK, 1 = WAIT, 2 = FAULT and 3 = protocol error. The engine makes no retry decision. A write to the target-select register in the debug port gets no reply on the wire, so for that request the engine ignores the acknowledge and finishes the write. After an access-port transfer that reached its data phase, the engine clocks the requested number of idle cycles with the line held low. This gives the target time, so that the next access is less likely to be answered with WAIT.

Top module: `swdh_engine`

## Requirements
- R1: The request packet is 8 bits, sent bit 0 first: bit0 start = 1, bit1 = port select (1 = access port), bit2 = direction (1 = read), bit3 = addr[0], bit4 = addr[1], bit5 = parity, bit6 stop = 0, bit7 park = 1. The park bit is actively driven (output enable high).
- R2: The packet parity bit is the XOR of port select, direction, addr[0] and addr[1], which gives even parity over those four bits.
- R3: After the request the host releases the line (output enable low) for one turnaround bit, and it keeps the line released through the three acknowledge bits.
- R4: The acknowledge is received bit 0 first. The pattern 3'b001 means OK, and the data phase follows.
- R5: An acknowledge of 3'b010 gives status 1 and 3'b100 gives status 2. Any other pattern gives status 3. In all three cases the transfer ends after one released turnaround bit, with no data phase and no idle cycles.
- R6: A debug-port write to address 2'b11 ignores the acknowledge bits. It continues with the write data phase and ends with status 0, whatever the target returned.
- R7: On a read the engine samples 32 data bits (bit 0 first) and then one parity bit while the line is released. One released turnaround bit follows, and the word appears on `rdata` at `done`.
- R8: On a read whose parity bit does not equal the XOR of the 32 data bits, the status is 3.
- R9: On a write, one released turnaround bit follows the acknowledge. The host then drives the 32 data bits (bit 0 first) and their even-parity bit.
- R10: After an access-port transfer that reached its data phase, the host clocks `req_idle` further cycles with the line driven low. Debug-port transfers get none, whatever the hint.
- R11: Each `swclk` half period lasts `cfg_half` system cycles, with 0 treated as 1. The host changes its line outputs only when a transfer starts or on a falling `swclk` edge. It samples the target on the rising edge. While idle, `swclk` is low and the line is driven low.
- R12: `req_ready` is high exactly when no transfer is in flight. A request is taken when `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse, and `status` and `rdata` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | Debug clock half period in system cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits [3:2] |
| req_wdata | input | 32 | Write data |
| req_idle | input | IDLE_W | Idle cycles to append after an access-port transfer |
| swclk | output | 1 | Debug clock |
| swdio_o | output | 1 | Line value driven by the host |
| swdio_oe | output | 1 | Host drives the line when high |
| swdio_i | input | 1 | Line value seen at the pad |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 0 OK, 1 WAIT, 2 FAULT, 3 protocol error |
| rdata | output | 32 | Read data of the last transfer |

## Verification
The bench plays the target. It checks every rising debug-clock edge against a bit-by-bit slot list built from the requirements, so a packet bit out of order, a wrong parity, or a line left driven during turnaround or acknowledge shows up at the exact bit. Corner cases covered are the target-select write answered with all-ones, which a design checking the acknowledge would report as a protocol error, and a debug-port read at the same address, which must not be excused. Idle hints are given on debug-port accesses and on WAIT, where appending cycles would leave extra clock edges. A flipped read parity bit must turn an otherwise good read into status 3. The transfer length is checked in system cycles against slot count and half period, which exposes a divider that miscounts or mishandles a zero setting.

// File: rtl/swdh_pkg.sv
package swdh_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FAULT = 2'd2,
    ST_PROT  = 2'd3
  } swdh_status_e;

  typedef enum logic [3:0] {
    PH_REQ, PH_TRN1, PH_ACK, PH_TRN2, PH_WDAT,
    PH_RDAT, PH_TRN3, PH_IDLE, PH_END
  } swdh_phase_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  // Packet bit 0 leaves the host first.
  function automatic logic [7:0] build_req(input logic ap, input logic rd,
                                           input logic [1:0] addr);
    return {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
  endfunction

  function automatic swdh_status_e decode_ack(input logic [2:0] ack);
    case (ack)
      ACK_OK:    return ST_OK;
      ACK_WAIT:  return ST_WAIT;
      ACK_FAULT: return ST_FAULT;
      default:   return ST_PROT;
    endcase
  endfunction

endpackage

// File: rtl/swdh_clkgen.sv
module swdh_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             swclk,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt;
  logic             hit;

  // A zero setting behaves like one.
  assign hit  = en && (({1'b0, cnt} + 1'b1) >= {1'b0, half});
  assign rise = hit && !swclk;
  assign fall = hit && swclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else if (hit) begin
      cnt   <= '0;
      swclk <= ~swclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/swdh_seq.sv
module swdh_seq
  import swdh_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req_ap,
  input  logic              req_read,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [IDLE_W-1:0] req_idle,
  input  logic              rise,
  input  logic              fall,
  input  logic              swdio_i,
  output logic              busy,
  output logic              swdio_o,
  output logic              swdio_oe,
  output logic              done,
  output logic [1:0]        status,
  output logic [31:0]       rdata
);

  localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

  swdh_phase_e       phase;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        r_pkt;
  logic [31:0]       r_wd;
  logic [IDLE_W-1:0] r_idle;
  logic              r_ap, r_rd, r_tsel, go_data;
  logic [1:0]        ack_sh;
  logic [31:0]       rd_sh;
  swdh_status_e      st;
  logic              drv_oe, drv_o;
  logic [2:0]        ack_full;
  swdh_phase_e       after_data;

  assign ack_full   = {swdio_i, ack_sh};
  assign after_data = (r_ap && (r_idle != '0)) ? PH_IDLE : PH_END;

  always_comb begin
    drv_oe = 1'b0;
    drv_o  = 1'b0;
    case (phase)
      PH_REQ:  begin drv_oe = 1'b1; drv_o = r_pkt[cnt[2:0]]; end
      PH_WDAT: begin drv_oe = 1'b1; drv_o = cnt[5] ? ^r_wd : r_wd[cnt[4:0]]; end
      PH_IDLE: drv_oe = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy     <= 1'b0;
      phase    <= PH_END;
      cnt      <= '0;
      swdio_oe <= 1'b1;
      swdio_o  <= 1'b0;
      status   <= ST_OK;
      rdata    <= '0;
      st       <= ST_OK;
      go_data  <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      phase    <= PH_REQ;
      cnt      <= '0;
      r_pkt    <= build_req(req_ap, req_read, req_addr);
      r_wd     <= req_wdata;
      r_idle   <= req_idle;
      r_ap     <= req_ap;
      r_rd     <= req_read;
      r_tsel   <= !req_ap && !req_read && (req_addr == 2'b11);
      st       <= ST_OK;
      swdio_oe <= 1'b1;
      swdio_o  <= 1'b1;
    end else if (busy && rise) begin
      case (phase)
        PH_REQ: begin
          if (cnt == CNT_W'(7)) begin phase <= PH_TRN1; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_TRN1: begin phase <= PH_ACK; cnt <= '0; end
        PH_ACK: begin
          if (cnt == CNT_W'(2)) begin
            cnt <= '0;
            if (r_tsel || ack_full == ACK_OK) begin
              st      <= ST_OK;
              go_data <= 1'b1;
              phase   <= r_rd ? PH_RDAT : PH_TRN2;
            end else begin
              st      <= decode_ack(ack_full);
              go_data <= 1'b0;
              phase   <= PH_TRN2;
            end
          end else begin
            ack_sh[cnt[0]] <= swdio_i;
            cnt <= cnt + 1'b1;
          end
        end
        PH_TRN2: begin phase <= go_data ? PH_WDAT : PH_END; cnt <= '0; end
        PH_WDAT: begin
          if (cnt[5]) begin phase <= after_data; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_RDAT: begin
          if (!cnt[5]) begin
            rd_sh <= {swdio_i, rd_sh[31:1]};
            cnt   <= cnt + 1'b1;
          end else begin
            if (swdio_i != ^rd_sh) st <= ST_PROT;
            phase <= PH_TRN3;
            cnt   <= '0;
          end
        end
        PH_TRN3: begin phase <= after_data; cnt <= '0; end
        PH_IDLE: begin
          if (CNT_W'(cnt + 1'b1) == CNT_W'(r_idle)) begin phase <= PH_END; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end else if (busy && fall) begin
      if (phase == PH_END) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        status   <= st;
        rdata    <= rd_sh;
        swdio_oe <= 1'b1;
        swdio_o  <= 1'b0;
      end else begin
        swdio_oe <= drv_oe;
        swdio_o  <= drv_o;
      end
    end
  end

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rise && phase == PH_REQ && cnt == '0) |-> (swdio_oe && swdio_o));
  // R1
  park_high_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rise && phase == PH_REQ && cnt == CNT_W'(7)) |-> (swdio_oe && swdio_o));
  // R3
  line_released_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rise && (phase == PH_TRN1 || phase == PH_ACK || phase == PH_RDAT ||
                      phase == PH_TRN3)) |-> !swdio_oe);
  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rise && phase == PH_IDLE) |-> (swdio_oe && !swdio_o));
  // R11
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(fall || start) |=> $stable({swdio_oe, swdio_o}));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(status) && $stable(rdata)));

endmodule

// File: rtl/swdh_engine.sv
module swdh_engine
  import swdh_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic              req_read,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [IDLE_W-1:0] req_idle,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i,
  output logic              done,
  output logic [1:0]        status,
  output logic [31:0]       rdata
);

  logic busy, rise, fall, start;

  assign req_ready = !busy;
  assign start     = req_valid && !busy;

  swdh_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk   (clk),
    .rst   (rst),
    .en    (busy),
    .half  (cfg_half),
    .swclk (swclk),
    .rise  (rise),
    .fall  (fall)
  );

  swdh_seq #(.IDLE_W(IDLE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_ap    (req_ap),
    .req_read  (req_read),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_idle  (req_idle),
    .rise      (rise),
    .fall      (fall),
    .swdio_i   (swdio_i),
    .busy      (busy),
    .swdio_o   (swdio_o),
    .swdio_oe  (swdio_oe),
    .done      (done),
    .status    (status),
    .rdata     (rdata)
  );

  // R11
  clk_parked_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !swclk);

endmodule

// File: tb/swdh_engine_tb.sv
module swdh_engine_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_half = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_ap = 1'b0, req_read = 1'b0;
  logic [1:0]  req_addr = 2'b00;
  logic [31:0] req_wdata = '0;
  logic [7:0]  req_idle = '0;
  logic        swclk, swdio_o, swdio_oe;
  logic        swdio_i = 1'b1;
  logic        done;
  logic [1:0]  status;
  logic [31:0] rdata;

  always #2 clk = ~clk;

  swdh_engine u_dut (
    .clk(clk), .rst(rst), .cfg_half(cfg_half), .req_valid(req_valid),
    .req_ready(req_ready), .req_ap(req_ap), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_idle(req_idle),
    .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i),
    .done(done), .status(status), .rdata(rdata)
  );

  typedef struct packed {
    logic       drv;
    logic       val;
    logic       tv;
    logic [3:0] rq;
  } slot_t;

  slot_t slots[$];
  int    vectors = 0;
  int    miss    = 0;
  int    cyc     = 0;
  logic  prev_sclk = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic drv, input logic val, input logic tv, input int rq);
    slot_t s;
    s.drv = drv; s.val = val; s.tv = tv; s.rq = 4'(rq);
    slots.push_back(s);
  endtask

  // Target model: checks the host at each rising debug-clock edge, drives after falls.
  always @(negedge clk) begin
    if (!rst) begin
      if (swclk && !prev_sclk) begin
        if (slots.size() == 0) begin
          chk("R11 extra swclk edge", 32'd1, 32'd0);
        end else begin
          slot_t s;
          s = slots.pop_front();
          chk($sformatf("R%0d line enable", s.rq), {31'd0, swdio_oe}, {31'd0, s.drv});
          if (s.drv) chk($sformatf("R%0d line value", s.rq), {31'd0, swdio_o}, {31'd0, s.val});
        end
      end
      if (!swclk && prev_sclk) swdio_i = (slots.size() != 0) ? slots[0].tv : 1'b1;
    end
    prev_sclk = swclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miss++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  task automatic xfer(input string tag, input logic ap, input logic rd, input logic [1:0] addr,
                      input logic [31:0] wd, input int idle, input logic [2:0] ack,
                      input logic [31:0] tdata, input logic flip, input int half);
    logic tsel, okp;
    int   exp_st, n, h, k;
    logic [7:0] pkt;
    tsel = !ap && !rd && addr == 2'b11;
    okp  = tsel || ack == 3'b001;
    // R1 R2: start, port, dir, a0, a1, parity, stop, park
    pkt = {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
    for (int i = 0; i < 8; i++) push(1'b1, pkt[i], 1'b1, (i == 5) ? 2 : 1);
    push(1'b0, 1'b0, 1'b1, 3);                                // R3 turnaround
    for (int i = 0; i < 3; i++) push(1'b0, 1'b0, ack[i], 3);  // R3 ack released
    if (!okp) begin
      push(1'b0, 1'b0, 1'b1, 5);                              // R5 trn, then end
      exp_st = (ack == 3'b010) ? 1 : (ack == 3'b100) ? 2 : 3;
    end else begin
      exp_st = 0;
      if (rd) begin
        for (int i = 0; i < 32; i++) push(1'b0, 1'b0, tdata[i], 7);  // R7
        push(1'b0, 1'b0, (^tdata) ^ flip, 8);                        // R8
        push(1'b0, 1'b0, 1'b1, 7);
        if (flip) exp_st = 3;
      end else begin
        push(1'b0, 1'b0, 1'b1, 9);                                   // R9
        for (int i = 0; i < 32; i++) push(1'b1, wd[i], 1'b1, 9);
        push(1'b1, ^wd, 1'b1, 9);
      end
      if (ap) for (int i = 0; i < idle; i++) push(1'b1, 1'b0, 1'b1, 10);  // R10
    end
    n = slots.size();
    h = (half == 0) ? 1 : half;
    cfg_half  = 8'(half);
    req_ap    = ap; req_read = rd; req_addr = addr;
    req_wdata = wd; req_idle = 8'(idle);
    chk({tag, " R12 ready before"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!done && k < 40000) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " R11 transfer length"}, 32'(k), 32'(2 * n * h + 1));
    chk({tag, " R5 status"}, {30'd0, status}, 32'(exp_st));
    if (rd && okp) chk({tag, " R7 rdata"}, rdata, tdata);
    chk({tag, " R10 slots left"}, 32'(slots.size()), 32'd0);
    slots.delete();
    @(negedge clk);
    chk({tag, " R12 done pulse"}, {31'd0, done}, 32'd0);
    chk({tag, " R11 idle line"}, {30'd0, swclk, swdio_oe}, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 R11 reset state
    chk("R12 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R12 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset swclk/oe/o", {29'd0, swclk, swdio_oe, swdio_o}, 32'b010);
    xfer("R4 R7 dp read",       1'b0, 1'b1, 2'b01, 32'h0,        4, 3'b001, 32'h1234_5678, 1'b0, 1);
    xfer("R9 dp write",         1'b0, 1'b0, 2'b10, 32'hA5A5_0F0F, 6, 3'b001, 32'h0,        1'b0, 2);
    xfer("R10 ap read idle",    1'b1, 1'b1, 2'b00, 32'h0,        3, 3'b001, 32'hDEAD_BEEF, 1'b0, 0);
    xfer("R10 ap write idle",   1'b1, 1'b0, 2'b11, 32'h8000_0001, 5, 3'b001, 32'h0,        1'b0, 3);
    xfer("R10 ap read no idle", 1'b1, 1'b1, 2'b10, 32'h0,        0, 3'b001, 32'h0000_0001, 1'b0, 1);
    xfer("R5 wait",             1'b1, 1'b1, 2'b01, 32'h0,        4, 3'b010, 32'h0,        1'b0, 1);
    xfer("R5 fault",            1'b0, 1'b0, 2'b01, 32'hFFFF_FFFF, 0, 3'b100, 32'h0,        1'b0, 2);
    xfer("R5 ack 111",          1'b0, 1'b1, 2'b00, 32'h0,        0, 3'b111, 32'h0,        1'b0, 1);
    xfer("R5 ack 011",          1'b1, 1'b0, 2'b10, 32'h0,        2, 3'b011, 32'h0,        1'b0, 1);
    xfer("R6 targetsel write",  1'b0, 1'b0, 2'b11, 32'h0100_2927, 0, 3'b111, 32'h0,        1'b0, 1);
    xfer("R6 targetsel ack 000",1'b0, 1'b0, 2'b11, 32'h7FFF_FFFE, 0, 3'b000, 32'h0,        1'b0, 2);
    xfer("R6 dp read addr3",    1'b0, 1'b1, 2'b11, 32'h0,        0, 3'b111, 32'h0,        1'b0, 1);
    xfer("R8 parity error",     1'b1, 1'b1, 2'b01, 32'h0,        2, 3'b001, 32'h0F0F_1234, 1'b1, 1);
    xfer("R8 good after bad",   1'b0, 1'b1, 2'b00, 32'h0,        0, 3'b001, 32'hFFFF_FFFF, 1'b0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

endmodule